// File: doc/BRIEF.md
# Reconfigurable Segmented Approximate Adder

This block adds two unsigned operands of a parameterised width. It splits them at a boundary that can be chosen at run time. Bit positions below the boundary produce their sum bit with no carry passing between them. Positions above the boundary form an ordinary carry-propagating adder, and that adder produces the carry-out. One carry crosses the boundary: the generate term of the highest carry-free position. This recovers the largest carry that would otherwise be lost, and it keeps the error below the weight of the boundary.

A two-bit mode code selects the boundary. An external monitor of process-variation severity drives this code. Code 0 gives the exact sum. Codes 1, 2 and 3 place progressively more low-order bits in the carry-free region, so the longest carry chain gets shorter as the reported severity rises. The adder is purely combinational and holds no state.

Top module: `reconf_approx_adder`

## Requirements
- R1: With mode code 0, {carry_out, sum} equals the exact sum of the two operands for every input pair.
- R2: With mode code 1, the 4 least significant sum bits each equal the XOR of the operand bits at the same position.
- R3: With mode code 2, the 6 least significant sum bits are the bitwise XOR of the operands. With mode code 3, the 8 least significant sum bits are the bitwise XOR of the operands.
- R4: In approximate modes with carry-free width k, sum bits k and above equal (opa >> k) + (opb >> k) + (opa[k-1] AND opb[k-1]), truncated to the sum width.
- R5: Carry-out is the bit that overflows from the upper segment, which is bit WIDTH of the value described in R1 or R4.
- R6: For every input, the approximate result is never larger than the exact sum, and the two differ by less than 2^k, where k is the carry-free width of the selected mode.
- R7: For a fixed operand pair, the error (exact minus approximate) does not decrease as the mode code goes from 0 to 3. The carry-free width increases strictly with the mode code.
- R8: The outputs depend only on the present inputs. A carry generated below the topmost carry-free position never reaches the upper segment. For example, 0x007F + 0x0001 in mode 3 gives 0x007E with carry-out 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| mode | input | 2 | Boundary select: 0 exact, 1/2/3 carry-free widths CF_W1/CF_W2/CF_W3 (defaults 4/6/8) |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the upper segment |

## Verification
The adder has no registers, so every result is due in the same cycle as the inputs that produce it. The bench applies each new operand pair and mode just after a rising clock edge and samples the outputs at the following falling edge. By then the inputs have settled and no other process is updating them. At that falling edge a behavioural model in the bench computes the expected sum and carry from the applied values, and the bench compares against it. The stimulus includes directed boundary cases, a fixed operand pair swept across all modes, and random vectors in every mode.

// File: rtl/sap_pkg.sv
package sap_pkg;

   typedef enum logic [1:0] {
      SAP_EXACT  = 2'd0,
      SAP_LIGHT  = 2'd1,
      SAP_MEDIUM = 2'd2,
      SAP_HEAVY  = 2'd3
   } sap_mode_e;

   localparam int SAP_MODE_W = 2;

endpackage

// File: rtl/sap_boundary_decode.sv
module sap_boundary_decode
   import sap_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int CF_W1 = 4,
   parameter int CF_W2 = 6,
   parameter int CF_W3 = 8,
   localparam int CW_W = $clog2(WIDTH + 1)
) (
   input  logic [SAP_MODE_W-1:0] mode,
   output logic [CW_W-1:0]       free_width,
   output logic [WIDTH-1:0]      free_mask,
   output logic [WIDTH-1:0]      top_mask
);

   always_comb begin
      case (sap_mode_e'(mode))
         SAP_EXACT:  free_width = '0;
         SAP_LIGHT:  free_width = CW_W'(CF_W1);
         SAP_MEDIUM: free_width = CW_W'(CF_W2);
         SAP_HEAVY:  free_width = CW_W'(CF_W3);
         default:    free_width = '0;
      endcase
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      assign free_mask[i] = CW_W'(i) < free_width;
      assign top_mask[i]  = CW_W'(i + 1) == free_width;
   end

   // R7: the carry-free region is a contiguous run from bit 0 with at most one top position
   always_comb begin
      a_r7_mask_contig: assert (((free_mask + 1'b1) & free_mask) == '0)
         else $error("carry-free mask not contiguous");
      a_r7_single_top: assert ($onehot0(top_mask))
         else $error("more than one boundary position");
      a_r7_top_in_mask: assert ((top_mask & ~free_mask) == '0)
         else $error("boundary position outside carry-free region");
   end

endmodule

// File: rtl/sap_bit_cell.sv
module sap_bit_cell (
   input  logic a,
   input  logic b,
   input  logic cin,
   input  logic free,
   input  logic top,
   output logic s,
   output logic cout
);

   logic gen;
   logic prop;

   assign gen  = a & b;
   assign prop = a ^ b;
   assign s    = prop ^ cin;

   // carry-free positions emit only their generate term, and only at the boundary
   assign cout = free ? (top & gen) : (gen | (prop & cin));

   // R2: a carry-free cell never receives a carry, so its sum is the plain XOR
   always_comb begin
      if (free) begin
         a_r2_free_no_cin: assert (cin == 1'b0)
            else $error("carry entered a carry-free position");
      end
   end

endmodule

// File: rtl/sap_carry_chain.sv
module sap_carry_chain #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [WIDTH-1:0] free_mask,
   input  logic [WIDTH-1:0] top_mask,
   output logic [WIDTH-1:0] s,
   output logic             cout
);

   logic [WIDTH:0] c;

   assign c[0] = 1'b0;

   for (genvar i = 0; i < WIDTH; i++) begin : g_cell
      sap_bit_cell u_cell (
         .a    (a[i]),
         .b    (b[i]),
         .cin  (c[i]),
         .free (free_mask[i]),
         .top  (top_mask[i]),
         .s    (s[i]),
         .cout (c[i+1])
      );
   end

   assign cout = c[WIDTH];

endmodule

// File: rtl/reconf_approx_adder.sv
module reconf_approx_adder
   import sap_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int CF_W1 = 4,
   parameter int CF_W2 = 6,
   parameter int CF_W3 = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [1:0]       mode,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);

   localparam int CW_W = $clog2(WIDTH + 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("WIDTH must be at least 2");
   end
   if (CF_W1 < 1) begin : g_bad_w1
      $error("CF_W1 must be at least 1");
   end
   if (!(CF_W1 < CF_W2 && CF_W2 < CF_W3)) begin : g_bad_order
      $error("carry-free widths must increase strictly with mode (R7)");
   end
   if (CF_W3 >= WIDTH) begin : g_bad_w3
      $error("CF_W3 must leave at least one carry-propagate bit");
   end

   logic [CW_W-1:0]  free_width;
   logic [WIDTH-1:0] free_mask;
   logic [WIDTH-1:0] top_mask;

   sap_boundary_decode #(
      .WIDTH (WIDTH),
      .CF_W1 (CF_W1),
      .CF_W2 (CF_W2),
      .CF_W3 (CF_W3)
   ) u_decode (
      .mode       (mode),
      .free_width (free_width),
      .free_mask  (free_mask),
      .top_mask   (top_mask)
   );

   sap_carry_chain #(
      .WIDTH (WIDTH)
   ) u_chain (
      .a         (opa),
      .b         (opb),
      .free_mask (free_mask),
      .top_mask  (top_mask),
      .s         (sum),
      .cout      (carry_out)
   );

   // checking logic: exact reference and error bound
   logic [WIDTH:0] chk_exact;
   logic [WIDTH:0] chk_approx;
   logic [WIDTH:0] chk_bound;

   assign chk_exact  = {1'b0, opa} + {1'b0, opb};
   assign chk_approx = {carry_out, sum};
   assign chk_bound  = (WIDTH + 1)'(1) << free_width;

   always_comb begin
      if (mode == 2'd0) begin
         a_r1_exact_mode: assert (chk_approx == chk_exact)
            else $error("exact mode result differs from true sum");
      end
      a_r6_no_overshoot: assert (chk_approx <= chk_exact)
         else $error("approximate result above exact sum");
      a_r6_err_bound: assert ((chk_exact - chk_approx) < chk_bound)
         else $error("approximation error not below 2^k");
   end

endmodule

// File: tb/reconf_approx_adder_test.sv
module reconf_approx_adder_test;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic [1:0]   mode = '0;
   logic [W-1:0] sum;
   logic         carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   reconf_approx_adder #(.WIDTH(W)) uut (
      .opa       (opa),
      .opb       (opb),
      .mode      (mode),
      .sum       (sum),
      .carry_out (carry_out)
   );

   function automatic int kw(input int m);
      case (m)
         1: return 4;
         2: return 6;
         3: return 8;
         default: return 0;
      endcase
   endfunction

   function automatic longint model(input int m, input longint a, input longint b);
      int k;
      longint msk, lo, cin, hi;
      k = kw(m);
      if (k == 0) return a + b;
      msk = (longint'(1) << k) - 1;
      lo  = (a ^ b) & msk;
      cin = (a >> (k - 1)) & (b >> (k - 1)) & 1;
      hi  = (a >> k) + (b >> k) + cin;
      return (hi << k) | lo;
   endfunction

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // apply after a rising edge, compare at the falling edge (combinational: due same cycle, R8)
   task automatic apply(input int m, input longint a, input longint b);
      longint act, exp, ex, mk;
      int k;
      @(posedge clk);
      mode = 2'(m);
      opa  = W'(a);
      opb  = W'(b);
      @(negedge clk);
      act = {47'd0, carry_out, sum};
      exp = model(m, a, b);
      ex  = a + b;
      k   = kw(m);
      mk  = (longint'(1) << k) - 1;
      case (m)
         0: check("R1 exact sum", act, ex);
         1: check("R2 low xor", act & mk, (a ^ b) & mk);
         default: check("R3 low xor", act & mk, (a ^ b) & mk);
      endcase
      if (m != 0)
         check("R4 upper segment", (act >> k) & ((longint'(1) << (W - k)) - 1),
               exp >> k & ((longint'(1) << (W - k)) - 1));
      check("R5 carry out", longint'(carry_out), (exp >> W) & 1);
      checks++;
      if (act > ex || (ex - act) >= (longint'(1) << k)) begin
         errors++;
         $display("FAIL R6 error bound: actual 0x%0h expected within 2^%0d of 0x%0h", act, k, ex);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      longint e [4];
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("reset state zero sum", {47'd0, carry_out, sum}, 0);

      // R8 cut carries and boundary cases
      apply(3, 64'h007F, 64'h0001);
      check("R8 lost low carry", {47'd0, carry_out, sum}, 64'h007E);
      apply(3, 64'h00FF, 64'h0080);
      check("R4 boundary carry recovered", {47'd0, carry_out, sum}, 64'h017F);
      apply(1, 64'hFFFF, 64'h0001);
      check("R5 no carry out when cut", {47'd0, carry_out, sum}, 64'hFFFE);
      apply(0, 64'hFFFF, 64'h0001);
      check("R1 wrap with carry out", {47'd0, carry_out, sum}, 64'h10000);
      apply(2, 64'hFFFF, 64'hFFFF);
      apply(0, 64'h0000, 64'h0000);

      // R7 error grows with mode for one operand pair
      for (int m = 0; m < 4; m++) begin
         apply(m, 64'h00FF, 64'h00FF);
         e[m] = 64'h01FE - longint'({carry_out, sum});
      end
      check("R7 mode1 error", e[1], 14);
      check("R7 mode2 error", e[2], 62);
      check("R7 mode3 error", e[3], 254);
      for (int m = 1; m < 4; m++) begin
         checks++;
         if (e[m] < e[m-1]) begin
            errors++;
            $display("FAIL R7 monotonic: actual %0d expected >= %0d", e[m], e[m-1]);
         end
      end

      // random vectors in every mode
      for (int i = 0; i < 2000; i++) begin
         apply(i % 4, longint'($urandom_range(0, 65535)), longint'($urandom_range(0, 65535)));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule